// File: doc/BRIEF.md
# Set-Associative Store Controller with Run-Time Write Policy

This block takes store requests (address, up to one word of byte data, and a byte count) and applies them to a set-associative data cache. A mode input chooses the write policy at run time. In copy-back mode, the line absorbs the store and memory is updated only when a dirty line is evicted. In write-through mode, the store always reaches memory, and the cache line is updated only on a hit. The controller holds the line data and the tag, valid, dirty and age state for every way. It chooses a victim that is not locked, writes that victim back when required, refills it, and merges the store bytes into the line.

A store to a non-cacheable window or a store made while the cache is disabled goes straight to memory and leaves the tag state as it is. A store is also sent to memory alone when it misses and every way is locked. A store whose line matches an outstanding request, given on a separate address input, waits in the controller and restarts once that request clears. The memory port carries either a single masked word write or a whole-line read or write. Each transfer is held until the memory acknowledges it.

Top module: `store_cache_ctrl`

## Requirements
- R1: After reset all lines are invalid, `req_rdy` is high and `mem_req` is low. `req_rdy` is high only while the controller is idle, and it falls on the cycle after a request is accepted (`req_vld` and `req_rdy` both high at a clock edge).
- R2: A store made while `cache_en` is low, or to an address where `(addr & NC_MASK) == NC_BASE`, produces exactly one word write to memory and no line transfer. A later cacheable store to the same line still misses.
- R3: A store that hits writes its bytes into the line, sets the dirty bit and makes the way the most recently used in its set. In copy-back mode a hit causes no memory traffic.
- R4: In write-through mode, a hit also sends a word write to memory and then clears the dirty bit, so a later eviction of that line writes nothing back. A write-through miss sends a word write only and allocates no line.
- R5: A copy-back miss reads the whole line from the store address with its offset bits cleared. It then merges the store bytes into the line, records the tag and sets the valid and dirty bits. It sends no word write.
- R6: When the chosen victim is both valid and dirty, a copy-back miss first writes the victim line back in full, at address {victim tag, set, zero offset}, and only then reads the new line.
- R7: The victim is the lowest-numbered invalid way that is not locked. If every unlocked way is valid, it is the least recently used unlocked way. Ages start at way index after reset, and the way with the highest age is least recent.
- R8: A miss with every bit of `lock_mask` set sends a word write to memory only, and allocates no line.
- R9: While `busy_vld` is high and `busy_addr` is in the same line as the accepted store, the store makes no memory transfer and `req_rdy` stays low. Processing resumes once the conflict clears.
- R10: `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_line` until `mem_ack`. `mem_line`=1 marks a whole-line transfer with `mem_bmask` all ones. For a word write (`mem_line`=0, `mem_we`=1), bit b of `mem_bmask` selects line byte b. The mask covers bytes offset to offset+len-1, and store byte k (bits 8k+7:8k of `req_data`) sits in line byte offset+k of `mem_wdata`.
- R11: `cb_mode` and `cache_en` are sampled when the request is accepted. Changing them while the store is in progress has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Cache enable, sampled at acceptance |
| cb_mode | input | 1 | 1 = copy-back, 0 = write-through; sampled at acceptance |
| lock_mask | input | WAYS | Per-way lock bit; a locked way is never chosen as victim |
| req_vld | input | 1 | Store request valid |
| req_rdy | output | 1 | Controller idle and able to accept |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | WORD_BYTES*8 | Store bytes, byte 0 in the low bits |
| req_len | input | $clog2(WORD_BYTES)+1 | Byte count, 1 to WORD_BYTES, not crossing a line |
| busy_vld | input | 1 | Another request is in flight |
| busy_addr | input | ADDR_W | Address of the in-flight request |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_line | output | 1 | 1 = whole line, 0 = single masked word |
| mem_addr | output | ADDR_W | Transfer address |
| mem_wdata | output | LINE_BYTES*8 | Write data, line-wide |
| mem_bmask | output | LINE_BYTES | Byte mask over the line |
| mem_ack | input | 1 | Transfer done; read data valid |
| mem_rdata | input | LINE_BYTES*8 | Line read data |

## Verification
The bench builds the controller with 2 ways, 2 sets, 8-byte lines, a 10-bit address and the non-cacheable window at 0x300 to 0x3FF. With only two ways per set, a short run of stores to distinct tags is enough to produce hits, invalid-way fills, dirty and clean evictions and LRU reordering. With a 1 KiB address space, the whole of memory fits in the bench's reference image. Several hundred generated stores, each with a different mode, enable, lock and length, sweep those paths. The expected sequence of memory transfers for each store is computed from a reference cache kept in the bench.

// File: rtl/scc_pkg.sv
package scc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_UPD,
    ST_MWR
  } scc_state_e;
endpackage

// File: rtl/scc_tag_store.sv
module scc_tag_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 64,
  parameter int TAG_W = 21,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SET_W-1:0]            rd_set,
  input  logic [TAG_W-1:0]            cmp_tag,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0]             rd_dirty,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0]             hit_vec,
  input  logic                        wr_en,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic                        clr_en,
  input  logic [SET_W-1:0]            clr_set,
  input  logic [WAY_W-1:0]            clr_way
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  // State bits: cleared by reset, written with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (wr_en) begin
        valid_q[wr_set][wr_way] <= 1'b1;
        dirty_q[wr_set][wr_way] <= 1'b1;
      end
      if (clr_en) begin
        dirty_q[clr_set][clr_way] <= 1'b0;
      end
    end
  end

  // Tag array: storage only, qualified by valid
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way] <= wr_tag;
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_valid[w] = valid_q[rd_set][w];
      rd_dirty[w] = dirty_q[rd_set][w];
      rd_tag[w]   = tag_q[rd_set][w];
      hit_vec[w]  = valid_q[rd_set][w] && (tag_q[rd_set][w] == cmp_tag);
    end
  end
endmodule

// File: rtl/scc_lru.sv
module scc_lru #(
  parameter int WAYS = 4,
  parameter int SETS = 64,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic [WAYS-1:0]  valid_in,
  input  logic [WAYS-1:0]  lock_in,
  output logic [WAY_W-1:0] victim,
  output logic             all_locked,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  // Age per way: 0 = most recent; a touched way goes to 0 and younger ways age by one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way) begin
          age_q[touch_set][w] <= '0;
        end else if (age_q[touch_set][w] < age_q[touch_set][touch_way]) begin
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
        end
      end
    end
  end

  // Victim: lowest free unlocked way, else oldest unlocked way
  always_comb begin
    logic             found_inv;
    logic             found_any;
    logic [WAY_W-1:0] best_age;
    found_inv = 1'b0;
    found_any = 1'b0;
    best_age  = '0;
    victim    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!lock_in[w] && !valid_in[w] && !found_inv) begin
        victim    = WAY_W'(w);
        found_inv = 1'b1;
      end
    end
    if (!found_inv) begin
      for (int w = 0; w < WAYS; w++) begin
        if (!lock_in[w] && (!found_any || age_q[rd_set][w] > best_age)) begin
          victim    = WAY_W'(w);
          best_age  = age_q[rd_set][w];
          found_any = 1'b1;
        end
      end
    end
    all_locked = &lock_in;
  end

  // R7
  victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_locked |-> !lock_in[victim]);
endmodule

// File: rtl/scc_line_ram.sv
module scc_line_ram #(
  parameter int WAYS   = 4,
  parameter int SETS   = 64,
  parameter int LINE_W = 256,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int DEPTH = WAYS * SETS
) (
  input  logic              clk,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WAY_W-1:0]  rd_way,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [LINE_W-1:0] wr_line
);
  logic [LINE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[{wr_set, wr_way}] <= wr_line;
    end
  end

  assign rd_line = mem_q[{rd_set, rd_way}];
endmodule

// File: rtl/store_cache_ctrl.sv
module store_cache_ctrl
  import scc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 4,
  parameter logic [ADDR_W-1:0] NC_MASK = ADDR_W'(32'hFF00_0000),
  parameter logic [ADDR_W-1:0] NC_BASE = ADDR_W'(32'hFF00_0000),
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int WORD_W = WORD_BYTES * 8,
  localparam int LEN_W  = $clog2(WORD_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              cb_mode,
  input  logic [WAYS-1:0]   lock_mask,
  input  logic              req_vld,
  output logic              req_rdy,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_data,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              busy_vld,
  input  logic [ADDR_W-1:0] busy_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_line,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  output logic [LINE_BYTES-1:0] mem_bmask,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rdata
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;

  scc_state_e st_q, st_d;

  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic [LEN_W-1:0]  len_q;
  logic              cb_q, en_q, hit_q, wrote_q;
  logic [WAY_W-1:0]  way_q;
  logic [LINE_W-1:0] fill_q;

  logic [SET_W-1:0]  set_q;
  logic [TAG_W-1:0]  tag_q;
  logic [OFF_W-1:0]  off_q;

  logic [WAYS-1:0]            rd_valid, rd_dirty, hit_vec;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAY_W-1:0]           victim, hit_way;
  logic                       all_locked, hit_any, bypass, conflict;
  logic                       accept, look_go;
  logic [LINE_W-1:0]          ram_line, src_line, merged, st_wdata;
  logic [LINE_BYTES-1:0]      st_mask;
  logic                       upd_en, clr_en;

  assign set_q = addr_q[OFF_W +: SET_W];
  assign tag_q = addr_q[ADDR_W-1 -: TAG_W];
  assign off_q = addr_q[OFF_W-1:0];

  // ---------------- state storage ----------------
  scc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (set_q),
    .cmp_tag  (tag_q),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .rd_tag   (rd_tag),
    .hit_vec  (hit_vec),
    .wr_en    (upd_en),
    .wr_set   (set_q),
    .wr_way   (way_q),
    .wr_tag   (tag_q),
    .clr_en   (clr_en),
    .clr_set  (set_q),
    .clr_way  (way_q)
  );

  scc_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_set     (set_q),
    .valid_in   (rd_valid),
    .lock_in    (lock_mask),
    .victim     (victim),
    .all_locked (all_locked),
    .touch_en   (upd_en),
    .touch_set  (set_q),
    .touch_way  (way_q)
  );

  scc_line_ram #(.WAYS(WAYS), .SETS(SETS), .LINE_W(LINE_W)) u_ram (
    .clk     (clk),
    .rd_set  (set_q),
    .rd_way  (way_q),
    .rd_line (ram_line),
    .wr_en   (upd_en),
    .wr_set  (set_q),
    .wr_way  (way_q),
    .wr_line (merged)
  );

  // ---------------- lookup decode ----------------
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit_any  = |hit_vec;
  assign bypass   = !en_q || ((addr_q & NC_MASK) == NC_BASE);
  assign conflict = busy_vld && ((busy_addr >> OFF_W) == (addr_q >> OFF_W));
  assign accept   = (st_q == ST_IDLE) && req_vld;
  assign look_go  = (st_q == ST_LOOK) && !conflict;

  // ---------------- store byte placement ----------------
  assign st_wdata = LINE_W'(data_q) << {off_q, 3'b000};

  always_comb begin
    for (int b = 0; b < LINE_BYTES; b++) begin
      st_mask[b] = (b >= int'(off_q)) && (b < int'(off_q) + int'(len_q));
    end
  end

  assign src_line = hit_q ? ram_line : fill_q;

  for (genvar gb = 0; gb < LINE_BYTES; gb++) begin : g_merge
    assign merged[gb*8 +: 8] = st_mask[gb] ? st_wdata[gb*8 +: 8] : src_line[gb*8 +: 8];
  end

  assign upd_en = (st_q == ST_UPD);
  assign clr_en = (st_q == ST_MWR) && mem_ack && wrote_q;

  // ---------------- next state ----------------
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_vld) st_d = ST_LOOK;
      ST_LOOK: begin
        if (!conflict) begin
          if (bypass)                                st_d = ST_MWR;
          else if (hit_any)                          st_d = ST_UPD;
          else if (!cb_q || all_locked)              st_d = ST_MWR;
          else if (rd_valid[victim] && rd_dirty[victim]) st_d = ST_WB;
          else                                       st_d = ST_FILL;
        end
      end
      ST_WB:   if (mem_ack) st_d = ST_FILL;
      ST_FILL: if (mem_ack) st_d = ST_UPD;
      ST_UPD:  st_d = cb_q ? ST_IDLE : ST_MWR;
      ST_MWR:  if (mem_ack) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      len_q   <= '0;
      cb_q    <= 1'b0;
      en_q    <= 1'b0;
      hit_q   <= 1'b0;
      wrote_q <= 1'b0;
      way_q   <= '0;
      fill_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q <= req_addr;
        data_q <= req_data;
        len_q  <= req_len;
        cb_q   <= cb_mode;
        en_q   <= cache_en;
      end
      if (look_go) begin
        hit_q   <= hit_any;
        way_q   <= hit_any ? hit_way : victim;
        wrote_q <= 1'b0;
      end
      if (upd_en) begin
        wrote_q <= 1'b1;
      end
      if ((st_q == ST_FILL) && mem_ack) begin
        fill_q <= mem_rdata;
      end
    end
  end

  // ---------------- outputs ----------------
  assign req_rdy = (st_q == ST_IDLE);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_line  = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = '0;
    mem_bmask = '0;
    unique case (st_q)
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_line  = 1'b1;
        mem_addr  = {rd_tag[way_q], set_q, {OFF_W{1'b0}}};
        mem_wdata = ram_line;
        mem_bmask = '1;
      end
      ST_FILL: begin
        mem_req   = 1'b1;
        mem_line  = 1'b1;
        mem_addr  = {tag_q, set_q, {OFF_W{1'b0}}};
        mem_bmask = '1;
      end
      ST_MWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = st_wdata;
        mem_bmask = st_mask;
      end
      default: ;
    endcase
  end

  // ---------------- assertions ----------------
  // R1
  rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_rdy) |=> !req_rdy);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_line)));

  // R9
  conflict_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_LOOK) && conflict) |=> ((st_q == ST_LOOK) && !mem_req));

  // R8
  locked_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (look_go && !bypass && !hit_any && all_locked) |=> (mem_req && !mem_line && mem_we));

  // R6
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WB) && mem_ack) |=> (mem_req && mem_line && !mem_we));

  // R3
  upd_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_UPD) |=> hit_vec[way_q]);
endmodule

// File: tb/test_store_cache_ctrl.sv
module test_store_cache_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b1;
  logic        cb_mode = 1'b1;
  logic [1:0]  lock_mask = 2'b00;
  logic        req_vld = 1'b0;
  logic        req_rdy;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_data = '0;
  logic [2:0]  req_len = 3'd1;
  logic        busy_vld = 1'b0;
  logic [9:0]  busy_addr = 10'h3FF;
  logic        mem_req, mem_we, mem_line;
  logic [9:0]  mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_bmask;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_cache_ctrl #(
    .ADDR_W(10), .WAYS(2), .SETS(2), .LINE_BYTES(8), .WORD_BYTES(4),
    .NC_MASK(10'h300), .NC_BASE(10'h300)
  ) i_store_cache_ctrl (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .cb_mode(cb_mode),
    .lock_mask(lock_mask), .req_vld(req_vld), .req_rdy(req_rdy),
    .req_addr(req_addr), .req_data(req_data), .req_len(req_len),
    .busy_vld(busy_vld), .busy_addr(busy_addr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_line(mem_line), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_bmask(mem_bmask), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  int errs = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Reference memory image (kept by the model, served by the responder)
  logic [7:0] gmem [1024];

  // Log of transfers seen on the memory port: kind 0 word write, 1 line write, 2 line read
  int          nact = 0;
  int          a_kind [4096];
  logic [9:0]  a_addr [4096];
  logic [63:0] a_data [4096];
  logic [7:0]  a_mask [4096];

  int          wcnt = 0;
  logic [9:0]  s_addr;
  logic        s_we, s_line;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst_n && mem_req && !mem_ack) begin
      if (wcnt == 0) begin
        s_addr <= mem_addr; s_we <= mem_we; s_line <= mem_line;
      end
      if (wcnt == LAT) begin
        wcnt <= 0;
        mem_ack <= 1'b1;
        // R10 fields held while waiting
        chk(s_addr == mem_addr && s_we == mem_we && s_line == mem_line,
            "R10 request fields held until ack", {s_addr, s_we, s_line}, {mem_addr, mem_we, mem_line});
        if (!mem_we) begin
          for (int b = 0; b < 8; b++) mem_rdata[b*8 +: 8] <= gmem[{mem_addr[9:3], 3'b000} + b];
        end
        if (nact < 4096) begin
          a_kind[nact] = !mem_we ? 2 : (mem_line ? 1 : 0);
          a_addr[nact] = mem_addr;
          a_data[nact] = mem_wdata;
          a_mask[nact] = mem_bmask;
          nact = nact + 1;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // Reference cache
  bit          m_val [2][2];
  bit          m_dty [2][2];
  int          m_age [2][2];
  logic [5:0]  m_tag [2][2];
  logic [63:0] m_dat [2][2];

  int          ne;
  int          e_kind [8];
  logic [9:0]  e_addr [8];
  logic [63:0] e_data [8];
  logic [7:0]  e_mask [8];

  function automatic logic [63:0] bytes_of(input logic [7:0] m);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = m[b] ? 8'hFF : 8'h00;
    return r;
  endfunction

  task automatic add_exp(input int k, input logic [9:0] a, input logic [63:0] d, input logic [7:0] m);
    e_kind[ne] = k; e_addr[ne] = a; e_data[ne] = d; e_mask[ne] = m;
    ne++;
  endtask

  task automatic touch(input int s, input int w);
    int old;
    old = m_age[s][w];
    for (int x = 0; x < 2; x++) begin
      if (x == w) m_age[s][x] = 0;
      else if (m_age[s][x] < old) m_age[s][x] = m_age[s][x] + 1;
    end
  endtask

  task automatic word_write(input logic [9:0] a, input logic [63:0] wd, input logic [7:0] mk);
    add_exp(0, a, wd & bytes_of(mk), mk);
    for (int b = 0; b < 8; b++) if (mk[b]) gmem[{a[9:3], 3'b000} + b] = wd[b*8 +: 8];
  endtask

  task automatic predict(input logic [9:0] a, input logic [31:0] d, input int len,
                         input bit cb, input bit en, input logic [1:0] lk);
    int s, hw, v, best, off;
    logic [5:0] tg;
    logic [7:0] mk;
    logic [63:0] wd, ln;
    ne  = 0;
    s   = int'(a[3]);
    tg  = a[9:4];
    off = int'(a[2:0]);
    mk  = 8'((9'(1) << len) - 1) << off;
    wd  = 64'(d) << (8 * off);
    if (!en || a[9:8] == 2'b11) begin
      word_write(a, wd, mk);
      return;
    end
    hw = -1;
    for (int w = 0; w < 2; w++) if (m_val[s][w] && m_tag[s][w] == tg) hw = w;
    if (hw >= 0) begin
      for (int b = 0; b < 8; b++) if (mk[b]) m_dat[s][hw][b*8 +: 8] = wd[b*8 +: 8];
      m_dty[s][hw] = 1;
      touch(s, hw);
      if (!cb) begin
        word_write(a, wd, mk);
        m_dty[s][hw] = 0;
      end
    end else if (lk == 2'b11 || !cb) begin
      word_write(a, wd, mk);
    end else begin
      v = -1;
      for (int w = 0; w < 2; w++) if (!lk[w] && !m_val[s][w] && v < 0) v = w;
      if (v < 0) begin
        best = -1;
        for (int w = 0; w < 2; w++) if (!lk[w] && m_age[s][w] > best) begin v = w; best = m_age[s][w]; end
      end
      if (m_val[s][v] && m_dty[s][v]) begin
        add_exp(1, {m_tag[s][v], s[0], 3'b000}, m_dat[s][v], 8'hFF);
        for (int b = 0; b < 8; b++) gmem[{m_tag[s][v], s[0], 3'b000} + b] = m_dat[s][v][b*8 +: 8];
      end
      add_exp(2, {a[9:3], 3'b000}, 64'h0, 8'hFF);
      for (int b = 0; b < 8; b++) ln[b*8 +: 8] = gmem[{a[9:3], 3'b000} + b];
      for (int b = 0; b < 8; b++) if (mk[b]) ln[b*8 +: 8] = wd[b*8 +: 8];
      m_dat[s][v] = ln; m_tag[s][v] = tg; m_val[s][v] = 1; m_dty[s][v] = 1;
      touch(s, v);
    end
  endtask

  task automatic do_store(input logic [9:0] a, input logic [31:0] d, input int len,
                          input bit cb, input bit en, input logic [1:0] lk,
                          input int hold, input bit flip, input string lbl);
    int start, tmo, got;
    predict(a, d, len, cb, en, lk);
    start = nact;
    @(negedge clk);
    lock_mask = lk; cb_mode = cb; cache_en = en;
    if (hold > 0) begin busy_vld = 1'b1; busy_addr = {a[9:3], 3'b101}; end
    req_vld = 1'b1; req_addr = a; req_data = d; req_len = 3'(len);
    @(negedge clk);
    req_vld = 1'b0;
    chk(req_rdy == 1'b0, {lbl, " / R1 ready low while busy"}, 64'(req_rdy), 64'd0);
    if (flip) begin cb_mode = !cb; cache_en = !en; end
    if (hold > 0) begin
      for (int i = 0; i < hold; i++) @(negedge clk);
      chk(nact == start && req_rdy == 1'b0, {lbl, " / R9 no transfer under conflict"},
          64'(nact - start), 64'd0);
      busy_vld = 1'b0;
    end
    tmo = 0;
    while (!req_rdy && tmo < 500) begin @(negedge clk); tmo++; end
    chk(tmo < 500, {lbl, " / R1 store completes"}, 64'(tmo), 64'd0);
    got = nact - start;
    chk(got == ne, {lbl, " / transfer count"}, 64'(got), 64'(ne));
    for (int i = 0; i < ne && i < got; i++) begin
      chk(a_kind[start+i] == e_kind[i], {lbl, " / transfer kind"}, 64'(a_kind[start+i]), 64'(e_kind[i]));
      chk(a_addr[start+i] == e_addr[i], {lbl, " / transfer address"}, 64'(a_addr[start+i]), 64'(e_addr[i]));
      if (e_kind[i] == 0) begin
        chk(a_mask[start+i] == e_mask[i], {lbl, " / R10 byte mask"}, 64'(a_mask[start+i]), 64'(e_mask[i]));
        chk((a_data[start+i] & bytes_of(e_mask[i])) == e_data[i], {lbl, " / R10 word data"},
            a_data[start+i] & bytes_of(e_mask[i]), e_data[i]);
      end else if (e_kind[i] == 1) begin
        chk(a_data[start+i] == e_data[i], {lbl, " / R6 written-back line"}, a_data[start+i], e_data[i]);
      end
    end
    cb_mode = cb; cache_en = en;
  endtask

  function automatic logic [31:0] lfsr(input logic [31:0] x);
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [9:0]  a;
    int          len, off;
    for (int i = 0; i < 1024; i++) gmem[i] = 8'(i * 7 + 3);
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 2; w++) begin
        m_val[s][w] = 0; m_dty[s][w] = 0; m_age[s][w] = w; m_tag[s][w] = '0; m_dat[s][w] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_rdy == 1'b1, "R1 ready after reset", 64'(req_rdy), 64'd1);
    chk(mem_req == 1'b0, "R1 no memory request after reset", 64'(mem_req), 64'd0);

    do_store(10'h010, 32'hA1A2A3A4, 4, 1, 1, 2'b00, 0, 0, "R5 copy-back miss fill");
    do_store(10'h012, 32'h000000B5, 1, 1, 1, 2'b00, 0, 0, "R3 copy-back hit");
    do_store(10'h030, 32'h0000C6C7, 2, 1, 1, 2'b00, 0, 0, "R7 free way first");
    do_store(10'h050, 32'h00D8D9DA, 3, 1, 1, 2'b00, 0, 0, "R6 dirty victim written back");
    do_store(10'h054, 32'hE1E2E3E4, 4, 0, 1, 2'b00, 0, 0, "R4 write-through hit");
    do_store(10'h070, 32'h11223344, 4, 1, 1, 2'b00, 0, 0, "R7 LRU victim");
    do_store(10'h090, 32'h55667788, 4, 1, 1, 2'b00, 0, 0, "R4 cleared dirty not written back");
    do_store(10'h0B0, 32'h99AABBCC, 4, 0, 1, 2'b00, 0, 0, "R4 write-through miss no allocate");
    do_store(10'h0C4, 32'h0000DDEE, 2, 1, 0, 2'b00, 0, 0, "R2 cache disabled");
    do_store(10'h0C5, 32'h000000FF, 1, 1, 1, 2'b00, 0, 0, "R2 line untouched by disabled store");
    do_store(10'h308, 32'h12345678, 4, 1, 1, 2'b00, 0, 0, "R2 uncached window");
    do_store(10'h30A, 32'h00009ABC, 2, 1, 1, 2'b00, 0, 0, "R2 uncached window repeat");
    do_store(10'h0D0, 32'h0BADF00D, 4, 1, 1, 2'b11, 0, 0, "R8 all ways locked");
    do_store(10'h0F8, 32'h00C0FFEE, 3, 1, 1, 2'b01, 0, 0, "R7 locked way skipped");
    do_store(10'h0E4, 32'h0000ABCD, 2, 1, 1, 2'b00, 6, 0, "R9 conflict requeue");
    do_store(10'h110, 32'h31415926, 4, 1, 1, 2'b00, 0, 1, "R11 mode sampled at accept");
    do_store(10'h114, 32'h27182818, 4, 0, 0, 2'b00, 0, 1, "R11 disable sampled at accept");

    r = 32'h1F2E3D4C;
    for (int n = 0; n < 500; n++) begin
      r = lfsr(lfsr(lfsr(r)));
      a = r[9:0] & 10'h33F;
      len = 1 + int'(r[14:13]);
      off = int'(a[2:0]);
      if (off + len > 8) a = a - 10'(off + len - 8);
      do_store(a, r ^ 32'h5A5A5A5A, len, r[16], r[19:17] != 3'b000,
               (r[22:20] == 3'b000) ? r[24:23] : 2'b00,
               (r[27:25] == 3'b000) ? 3 : 0, r[30:28] == 3'b000, "R10 sweep");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule